// File: doc/BRIEF.md
# Streaming Codeword Histogram Chain

This block turns a stream of codeword indices into a bag-of-words histogram with one bin per codeword. The bins are held in a linear chain of nodes, and each node owns exactly one bin. An accepted index enters the chain at the head and moves one node per clock. The node whose bin number equals the index adds one to its count and takes the index out of the chain. Every other node hands the index on to the next node. An index that matches no bin leaves the chain at the tail and changes nothing.

Because each hop between nodes is registered, the block accepts a new index on every cycle. An intake counter tracks how many indices have been accepted. When the configured total for one video has arrived, the block closes its input and waits one full chain length, so that every index still in flight reaches its node. It then shifts the counts out one bin per cycle in ascending bin order. Zeros are shifted in behind the counts, so the bins are empty when the next video starts. The block marks the first beat of a histogram with a done flag and the final beat with a last flag.

Top module: `hist_chain_top`

## Requirements
- R1: Reset, whether asserted at start-up or partway through a collection, leaves in_ready high, out_valid and done low, and every bin at zero.
- R2: Each accepted index below NUM_BINS increases the count of exactly the bin with that number by one. Each bin's count appears on out_count during its readout beat.
- R3: An accepted index of NUM_BINS or above counts toward the per-video total and changes no bin.
- R4: From the cycle after the TOTAL-th index is accepted, in_ready stays low through the drain period and the whole readout.
- R5: The first readout beat appears exactly NUM_BINS+1 cycles after the cycle in which the TOTAL-th index is accepted.
- R6: Readout consists of NUM_BINS consecutive cycles with out_valid high. Beat j carries the count of bin j, starting at bin 0.
- R7: done is high only on the first readout beat (bin 0).
- R8: out_last is high only on the final readout beat (bin NUM_BINS-1).
- R9: In the cycle after the final beat, out_valid is low and in_ready is high. The next histogram starts from all-zero bins.
- R10: An index offered while in_ready is low is not accepted and affects no bin.
- R11: Cycles with in_valid low add nothing to the total or to any bin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An index is offered this cycle |
| in_idx | input | IDX_W | Codeword index offered |
| in_ready | output | 1 | The block accepts an index this cycle |
| out_valid | output | 1 | A readout beat is present |
| out_count | output | CNT_W | Count of the bin being read out (zero when idle) |
| out_last | output | 1 | The beat carries the highest-numbered bin |
| done | output | 1 | The beat is the first of a finished histogram |

## Verification
The bound checker watches the framing of the readout on every cycle. It checks that the input stays closed while beats flow, that the beats form one unbroken run, that done sits on the opening beat and out_last on a beat, and that intake reopens right after the closing beat. The bench scenarios are the only way to show that the counts themselves are right: which bin each index reaches, that out-of-range and refused indices are dropped, the exact drain latency, and the return to zero between videos. The bench covers these with dense, sparse, single-bin and out-of-range index streams.

// File: rtl/hist_pkg.sv
package hist_pkg;
    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_DUMP    = 2'd2
    } hist_state_e;
endpackage

// File: rtl/hist_node.sv
module hist_node #(
    parameter int IDX_W  = 10,
    parameter int CNT_W  = 14,
    parameter int BIN_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_vld,
    input  logic [IDX_W-1:0] up_idx,
    input  logic             shift_en,
    input  logic [CNT_W-1:0] shift_in,
    output logic             dn_vld,
    output logic [IDX_W-1:0] dn_idx,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [IDX_W-1:0] MY_BIN = IDX_W'(BIN_ID);

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
    } node_t;

    node_t st_q, st_d;
    logic  hit;

    assign hit = st_q.vld && (st_q.idx == MY_BIN);

    always_comb begin
        st_d     = st_q;
        st_d.vld = up_vld;
        st_d.idx = up_idx;
        if (shift_en) begin
            st_d.cnt = shift_in;
        end else if (hit) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A matched index is consumed here; only misses travel on.
    assign dn_vld = st_q.vld && !hit;
    assign dn_idx = st_q.idx;
    assign cnt    = st_q.cnt;
endmodule

// File: rtl/hist_ctrl.sv
module hist_ctrl
    import hist_pkg::*;
#(
    parameter int NUM_BINS = 1000,
    parameter int TOTAL    = 10241
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic accept,
    output logic in_ready,
    output logic dump_en,
    output logic out_last,
    output logic done
);
    localparam int RCV_W = (TOTAL > 1) ? $clog2(TOTAL) : 1;
    localparam int SEQ_W = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1;
    localparam logic [RCV_W-1:0] LAST_RCV = RCV_W'(TOTAL - 1);
    localparam logic [SEQ_W-1:0] LAST_SEQ = SEQ_W'(NUM_BINS - 1);

    typedef struct packed {
        hist_state_e      st;
        logic [RCV_W-1:0] rcv;
        logic [SEQ_W-1:0] seq;
    } ctrl_t;

    ctrl_t cs_q, cs_d;

    assign in_ready = (cs_q.st == ST_COLLECT);
    assign accept   = in_valid && in_ready;
    assign dump_en  = (cs_q.st == ST_DUMP);
    assign out_last = dump_en && (cs_q.seq == LAST_SEQ);
    assign done     = dump_en && (cs_q.seq == '0);

    always_comb begin
        cs_d = cs_q;
        unique case (cs_q.st)
            ST_COLLECT: begin
                if (accept) begin
                    if (cs_q.rcv == LAST_RCV) begin
                        cs_d.rcv = '0;
                        cs_d.seq = '0;
                        cs_d.st  = ST_DRAIN;
                    end else begin
                        cs_d.rcv = cs_q.rcv + 1'b1;
                    end
                end
            end
            ST_DRAIN: begin
                // One cycle per node so the final index can reach the tail.
                if (cs_q.seq == LAST_SEQ) begin
                    cs_d.seq = '0;
                    cs_d.st  = ST_DUMP;
                end else begin
                    cs_d.seq = cs_q.seq + 1'b1;
                end
            end
            ST_DUMP: begin
                if (cs_q.seq == LAST_SEQ) begin
                    cs_d.seq = '0;
                    cs_d.st  = ST_COLLECT;
                end else begin
                    cs_d.seq = cs_q.seq + 1'b1;
                end
            end
            default: begin
                cs_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end
endmodule

// File: rtl/hist_chain_top.sv
module hist_chain_top #(
    parameter int NUM_BINS = 1000,
    parameter int IDX_W    = 10,
    parameter int CNT_W    = 14,
    parameter int TOTAL    = 10241
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IDX_W-1:0] in_idx,
    output logic             in_ready,
    output logic             out_valid,
    output logic [CNT_W-1:0] out_count,
    output logic             out_last,
    output logic             done
);
    logic             accept;
    logic             dump_en;
    logic             hop_vld [NUM_BINS+1];
    logic [IDX_W-1:0] hop_idx [NUM_BINS+1];
    logic [CNT_W-1:0] bin_cnt [NUM_BINS];

    hist_ctrl #(
        .NUM_BINS (NUM_BINS),
        .TOTAL    (TOTAL)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .accept   (accept),
        .in_ready (in_ready),
        .dump_en  (dump_en),
        .out_last (out_last),
        .done     (done)
    );

    assign hop_vld[0] = accept;
    assign hop_idx[0] = in_idx;

    for (genvar b = 0; b < NUM_BINS; b++) begin : g_node
        logic [CNT_W-1:0] feed_cnt;
        if (b == NUM_BINS - 1) begin : g_tail
            assign feed_cnt = '0;
        end else begin : g_body
            assign feed_cnt = bin_cnt[b+1];
        end

        hist_node #(
            .IDX_W  (IDX_W),
            .CNT_W  (CNT_W),
            .BIN_ID (b)
        ) node_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .up_vld   (hop_vld[b]),
            .up_idx   (hop_idx[b]),
            .shift_en (dump_en),
            .shift_in (feed_cnt),
            .dn_vld   (hop_vld[b+1]),
            .dn_idx   (hop_idx[b+1]),
            .cnt      (bin_cnt[b])
        );
    end

    assign out_valid = dump_en;
    assign out_count = dump_en ? bin_cnt[0] : '0;
endmodule

// File: rtl/hist_chain_chk.sv
module hist_chain_chk (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic out_valid,
    input logic out_last,
    input logic done
);
    assert_input_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_beats_unbroken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid);

    assert_done_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> done);

    assert_done_on_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> out_valid);

    assert_last_on_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    assert_reopen_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> (!out_valid && in_ready));
endmodule

bind hist_chain_top hist_chain_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .done      (done)
);

// File: tb/hist_chain_tb.sv
module hist_chain_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB    = 8;
    localparam int IW    = 4;
    localparam int CW    = 5;
    localparam int LEN   = 12;
    localparam int NSCEN = 4;

    // Per scenario: index stream (values >= NB are out of range).
    localparam logic [IW-1:0] VEC [NSCEN][LEN] = '{
        '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd0, 4'd1, 4'd2, 4'd3},
        '{4'd7, 4'd7, 4'd7, 4'd7, 4'd7, 4'd7, 4'd7, 4'd7, 4'd7, 4'd7, 4'd7, 4'd7},
        '{4'd3, 4'd9, 4'd15, 4'd3, 4'd0, 4'd8, 4'd12, 4'd7, 4'd3, 4'd11, 4'd0, 4'd3},
        '{4'd5, 4'd5, 4'd2, 4'd6, 4'd1, 4'd5, 4'd0, 4'd4, 4'd2, 4'd6, 4'd7, 4'd5}
    };
    // Requirement each scenario's bin counts stand for.
    localparam string TAGS [NSCEN] = '{"R2", "R10", "R3", "R11"};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [IW-1:0] in_idx = '0;
    logic          in_ready;
    logic          out_valid;
    logic [CW-1:0] out_count;
    logic          out_last;
    logic          done;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hist_chain_top #(
        .NUM_BINS (NB),
        .IDX_W    (IW),
        .CNT_W    (CW),
        .TOTAL    (LEN)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_idx    (in_idx),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_count (out_count),
        .out_last  (out_last),
        .done      (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_hist(input int s, input bit gaps, input string tag);
        int exp_cnt [NB];
        int k;
        int open_cycles;
        bit seen;
        for (int b = 0; b < NB; b++) exp_cnt[b] = 0;
        for (int i = 0; i < LEN; i++) begin
            if (int'(VEC[s][i]) < NB) exp_cnt[VEC[s][i]]++;
        end
        for (int i = 0; i < LEN; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_idx   = VEC[s][i];
            if (gaps && i < LEN - 1) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_idx   = 4'd1;
            end
        end
        // Drain: keep offering junk index 0, which must be refused (R10).
        k = 0;
        seen = 1'b0;
        open_cycles = 0;
        while (!seen && k < NB + 8) begin
            @(negedge clk);
            k++;
            in_valid = 1'b1;
            in_idx   = '0;
            if (done) seen = 1'b1;
            else if (in_ready) open_cycles++;
        end
        check(open_cycles == 0, "R4", open_cycles, 0);
        check(k == NB + 1, "R5", k, NB + 1);
        for (int j = 0; j < NB; j++) begin
            if (j > 0) @(negedge clk);
            check(out_valid == 1'b1, "R6", int'(out_valid), 1);
            check(!in_ready, "R4", int'(in_ready), 0);
            check(int'(out_count) == exp_cnt[j], tag, int'(out_count), exp_cnt[j]);
            check(out_last == (j == NB - 1), "R8", int'(out_last), int'(j == NB - 1));
            check(done == (j == 0), "R7", int'(done), int'(j == 0));
        end
        @(negedge clk);
        in_valid = 1'b0;
        check(in_ready && !out_valid, "R9", int'({in_ready, out_valid}), 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(in_ready == 1'b1, "R1", int'(in_ready), 1);
        check(!out_valid && !done, "R1", int'({out_valid, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1", int'(in_ready), 1);

        // Table walk: back-to-back histograms, scenario 3 with idle gaps.
        for (int s = 0; s < NSCEN; s++) begin
            run_hist(s, s == 3, TAGS[s]);
        end
        // R9: bins start from zero again after a readout.
        run_hist(1, 1'b0, "R9");

        // R1: reset in the middle of a collection discards partial counts.
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_idx   = 4'd2;
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        check(in_ready && !out_valid && !done, "R1", int'({in_ready, out_valid, done}), 4);
        rst_n = 1'b1;
        run_hist(0, 1'b0, "R1");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=completed");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule